// File: doc/BRIEF.md
# Doorbell Interrupt Register Bank

This block is the register front end of a shared-memory endpoint that talks to peer nodes. Software reaches it through a 256-byte, word-wide register window with a request/response handshake. Every request is answered one cycle later. The window holds four registers:

- an interrupt enable mask;
- an interrupt status register that clears when it is read;
- a read-only word that reports the node's own position;
- a write-only doorbell.

A doorbell write names a destination peer and a vector. The block checks both against a sideband table of per-peer vector counts. A valid ring becomes a one-cycle notify pulse toward the fabric. An invalid ring is dropped without any trace.

The block runs in one of two interrupt styles, chosen by `msi_mode_i`:

- **Line mode.** The level interrupt output follows the masked status, and event pulses arriving on the node's own vectors load the status register with 1.
- **Message mode.** The line stays low, and incoming events leave the status register alone. Delivery of those events is handled elsewhere.

Top module: `dbell_regbank`

## Requirements
- R1: After reset the mask and status registers are zero, `irq_o` is low, `ring_o` is low and `rsp_valid_o` is low.
- R2: Every cycle with `req_i` high is answered by `rsp_valid_o` high in the next cycle. Read data appears on `rdata_o` in that same cycle. `rsp_valid_o` is low in the cycle after a cycle without a request.
- R3: A write to byte offset 0x00 (mask) or 0x04 (status) replaces all 32 bits of that register. Reads return the stored value. For writes, address bits 1:0 are ignored.
- R4: A read of the status register returns its value and leaves the register at zero, so an immediate second read returns 0.
- R5: When `msi_mode_i` is 0, `irq_o` equals the OR of (status AND mask) in the cycle after any register change. When `msi_mode_i` is 1, `irq_o` is low.
- R6: When `msi_mode_i` is 0, any high bit on `event_i` loads the status register with the value 1. When `msi_mode_i` is 1, events have no effect. In a single cycle, a bus write to status wins over an event, and an event wins over the clear caused by a status read.
- R7: A read of byte offset 0x08 returns `own_pos_i` zero-extended to 32 bits. Writes to 0x08 have no effect.
- R8: A write to byte offset 0x0C takes the destination peer from bits 31:16 and the vector from bits 7:0; bits 15:8 are ignored. If the ring is valid, then in the next cycle `ring_o` is high for one cycle, with `ring_peer_o` and `ring_vec_o` carrying the destination and vector.
- R9: A doorbell is dropped, with no pulse, when any of these holds:
  - the destination is not below `num_peers_i`;
  - the destination is not below the table depth;
  - the vector is not below that peer's count in `peer_vec_cnt_i`.
  Peer p's count occupies bits [p*CNT_W +: CNT_W].
- R10: Reads of undefined or misaligned offsets, including the write-only doorbell, return 0. Writes to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_mode_i | input | 1 | 1 selects message interrupt style (line held low) |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response, one cycle after request |
| rdata_o | output | 32 | Read data, valid with rsp_valid_o |
| own_pos_i | input | 16 | This node's position |
| num_peers_i | input | 16 | Number of peers currently known |
| peer_vec_cnt_i | input | MAX_PEERS*CNT_W | Per-peer vector counts |
| event_i | input | NUM_OWN_VECS | Incoming event pulses on own vectors |
| irq_o | output | 1 | Level interrupt line |
| ring_o | output | 1 | Doorbell notify pulse |
| ring_peer_o | output | 16 | Destination peer of the notify |
| ring_vec_o | output | 8 | Vector of the notify |

## Verification
On every cycle, the embedded assertions check:
- the one-cycle response timing;
- the full-word mask overwrite;
- the read-to-clear and event-load updates of status;
- that the line stays low in message mode;
- that every notify pulse follows a doorbell write to an in-range peer, with its outputs held between pulses;
- that undefined reads return zero.

Some behaviour shows only in the bench's scenarios, where a reference model tracks the mask and status through random traffic:
- the drop rules that depend on the sideband table contents;
- the same-cycle priorities between a status write, an event and a read-clear;
- the ignored doorbell bits 15:8;
- the fact that writes to the position or undefined offsets leave state unchanged.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int WIN_ADDR_W = 8;
  localparam int WORD_IDX_W = WIN_ADDR_W - 2;
  localparam int REG_W      = 32;
  localparam int PEER_W     = 16;
  localparam int VEC_W      = 8;

  // word indices; software relies on these offsets
  localparam logic [WORD_IDX_W-1:0] IDX_MASK = 6'd0;
  localparam logic [WORD_IDX_W-1:0] IDX_STAT = 6'd1;
  localparam logic [WORD_IDX_W-1:0] IDX_POS  = 6'd2;
  localparam logic [WORD_IDX_W-1:0] IDX_BELL = 6'd3;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_POS  = 2'd3
  } rsel_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
(
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [WIN_ADDR_W-1:0] addr_i,
  output logic                  wr_mask_o,
  output logic                  wr_stat_o,
  output logic                  wr_bell_o,
  output logic                  rd_stat_o,
  output rsel_e                 rsel_o
);
  logic [WORD_IDX_W-1:0] word;
  logic                  wr, rd;

  assign word = addr_i[WIN_ADDR_W-1:2];
  assign wr   = req_i && we_i;
  // reads must be word aligned; writes ignore the byte lane bits
  assign rd   = req_i && !we_i && (addr_i[1:0] == 2'b00);

  assign wr_mask_o = wr && (word == IDX_MASK);
  assign wr_stat_o = wr && (word == IDX_STAT);
  assign wr_bell_o = wr && (word == IDX_BELL);
  assign rd_stat_o = rd && (word == IDX_STAT);

  always_comb begin
    rsel_o = RSEL_NONE;
    if (rd) begin
      unique case (word)
        IDX_MASK: rsel_o = RSEL_MASK;
        IDX_STAT: rsel_o = RSEL_STAT;
        IDX_POS:  rsel_o = RSEL_POS;
        default:  rsel_o = RSEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dbell_irq.sv
module dbell_irq
  import dbell_pkg::*;
#(
  parameter int NUM_OWN_VECS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    msi_mode_i,
  input  logic                    wr_mask_i,
  input  logic                    wr_stat_i,
  input  logic                    rd_stat_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [NUM_OWN_VECS-1:0] event_i,
  output logic [REG_W-1:0]        mask_o,
  output logic [REG_W-1:0]        stat_o,
  output logic                    irq_o
);
  logic [REG_W-1:0] mask_q, stat_q;
  logic             ev_line;

  assign ev_line = !msi_mode_i && (|event_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_mask_i) begin
      mask_q <= wdata_i;
    end
  end

  // priority: bus write > event > read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (wr_stat_i) begin
      stat_q <= wdata_i;
    end else if (ev_line) begin
      stat_q <= REG_W'(1);
    end else if (rd_stat_i) begin
      stat_q <= '0;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = !msi_mode_i && (|(stat_q & mask_q));

  assert_mask_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> mask_q == $past(wdata_i));

  assert_stat_rdclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !wr_stat_i && !ev_line) |=> stat_q == '0);

  assert_event_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_line && !wr_stat_i) |=> stat_q == REG_W'(1));

  assert_msi_ignores_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_mode_i && !wr_stat_i && !rd_stat_i) |=> $stable(stat_q));
endmodule

// File: rtl/dbell_ring.sv
module dbell_ring
  import dbell_pkg::*;
#(
  parameter int MAX_PEERS = 16,
  parameter int CNT_W     = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fire_i,
  input  logic [PEER_W-1:0]          dest_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  logic [PEER_W-1:0]          num_peers_i,
  input  logic [MAX_PEERS*CNT_W-1:0] cnt_tbl_i,
  output logic                       ring_o,
  output logic [PEER_W-1:0]          ring_peer_o,
  output logic [VEC_W-1:0]           ring_vec_o
);
  localparam int CMP_W = (CNT_W > VEC_W) ? CNT_W : VEC_W;

  logic [CNT_W-1:0]  sel_cnt;
  logic              peer_in, vec_ok, hit;
  logic              ring_q;
  logic [PEER_W-1:0] peer_q;
  logic [VEC_W-1:0]  vec_q;

  always_comb begin
    sel_cnt = '0;
    for (int p = 0; p < MAX_PEERS; p++) begin
      if (32'(dest_i) == p) sel_cnt = cnt_tbl_i[p*CNT_W +: CNT_W];
    end
  end

  assign peer_in = (dest_i < num_peers_i) && (32'(dest_i) < MAX_PEERS);
  assign vec_ok  = CMP_W'(vec_i) < CMP_W'(sel_cnt);
  assign hit     = fire_i && peer_in && vec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= 1'b0;
      peer_q <= '0;
      vec_q  <= '0;
    end else begin
      ring_q <= hit;
      if (hit) begin
        peer_q <= dest_i;
        vec_q  <= vec_i;
      end
    end
  end

  assign ring_o      = ring_q;
  assign ring_peer_o = peer_q;
  assign ring_vec_o  = vec_q;

  assert_ring_from_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_o |-> $past(fire_i));

  assert_ring_peer_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_o |-> (ring_peer_o < $past(num_peers_i)));

  assert_ring_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fire_i) |-> ($stable(ring_peer_o) && $stable(ring_vec_o) && !ring_o));
endmodule

// File: rtl/dbell_regbank.sv
module dbell_regbank
  import dbell_pkg::*;
#(
  parameter int MAX_PEERS    = 16,
  parameter int MAX_VECS     = 32,
  parameter int NUM_OWN_VECS = 4,
  localparam int CNT_W       = $clog2(MAX_VECS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       msi_mode_i,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [7:0]                 addr_i,
  input  logic [31:0]                wdata_i,
  output logic                       rsp_valid_o,
  output logic [31:0]                rdata_o,
  input  logic [15:0]                own_pos_i,
  input  logic [15:0]                num_peers_i,
  input  logic [MAX_PEERS*CNT_W-1:0] peer_vec_cnt_i,
  input  logic [NUM_OWN_VECS-1:0]    event_i,
  output logic                       irq_o,
  output logic                       ring_o,
  output logic [15:0]                ring_peer_o,
  output logic [7:0]                 ring_vec_o
);
  logic             wr_mask, wr_stat, wr_bell, rd_stat;
  rsel_e            rsel;
  logic [REG_W-1:0] mask, stat;
  logic             rsp_q;
  logic [REG_W-1:0] rdata_q, rd_mux;

  dbell_decode u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wr_mask_o (wr_mask),
    .wr_stat_o (wr_stat),
    .wr_bell_o (wr_bell),
    .rd_stat_o (rd_stat),
    .rsel_o    (rsel)
  );

  dbell_irq #(.NUM_OWN_VECS(NUM_OWN_VECS)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msi_mode_i (msi_mode_i),
    .wr_mask_i  (wr_mask),
    .wr_stat_i  (wr_stat),
    .rd_stat_i  (rd_stat),
    .wdata_i    (wdata_i),
    .event_i    (event_i),
    .mask_o     (mask),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  dbell_ring #(.MAX_PEERS(MAX_PEERS), .CNT_W(CNT_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (wr_bell),
    .dest_i      (wdata_i[31:16]),
    .vec_i       (wdata_i[7:0]),
    .num_peers_i (num_peers_i),
    .cnt_tbl_i   (peer_vec_cnt_i),
    .ring_o      (ring_o),
    .ring_peer_o (ring_peer_o),
    .ring_vec_o  (ring_vec_o)
  );

  always_comb begin
    unique case (rsel)
      RSEL_MASK: rd_mux = mask;
      RSEL_STAT: rd_mux = stat;
      RSEL_POS:  rd_mux = REG_W'(own_pos_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q   <= req_i;
      rdata_q <= (req_i && !we_i) ? rd_mux : '0;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rdata_o     = rdata_q;

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  assert_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  assert_msi_line_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_mode_i |-> !irq_o);

  assert_undef_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i[7:4] != 4'd0 || addr_i[3:2] == 2'd3 || addr_i[1:0] != 2'd0))
      |=> rdata_o == '0);
endmodule

// File: tb/tb_dbell_regbank.sv
`timescale 1ns/1ps
module tb_dbell_regbank;
  localparam int MAX_PEERS = 16;
  localparam int MAX_VECS  = 32;
  localparam int NOV       = 4;
  localparam int CNT_W     = $clog2(MAX_VECS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi_mode = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid;
  logic [31:0] rdata;
  logic [15:0] own_pos = 16'h0a5c;
  logic [15:0] num_peers = 16'd10;
  logic [MAX_PEERS*CNT_W-1:0] cnt_tbl = '0;
  logic [NOV-1:0] ev = '0;
  logic        irq, ring;
  logic [15:0] ring_peer;
  logic [7:0]  ring_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mask_m = '0, stat_m = '0;
  int cnt_m [MAX_PEERS];

  always #2.5 clk = ~clk;

  dbell_regbank #(.MAX_PEERS(MAX_PEERS), .MAX_VECS(MAX_VECS), .NUM_OWN_VECS(NOV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .msi_mode_i(msi_mode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rdata_o(rdata),
    .own_pos_i(own_pos), .num_peers_i(num_peers), .peer_vec_cnt_i(cnt_tbl),
    .event_i(ev), .irq_o(irq), .ring_o(ring), .ring_peer_o(ring_peer), .ring_vec_o(ring_vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit db_valid(input logic [31:0] d);
    int dest = int'(d[31:16]);
    int vec = int'(d[7:0]);
    if (dest >= int'(num_peers) || dest >= MAX_PEERS) return 0;
    return vec < cnt_m[dest];
  endfunction

  function automatic logic [31:0] rd_exp(input logic [7:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[7:2])
      6'd0: return mask_m;
      6'd1: return stat_m;
      6'd2: return {16'h0, own_pos};
      default: return '0;
    endcase
  endfunction

  function automatic bit irq_exp();
    return !msi_mode && (|(stat_m & mask_m));
  endfunction

  // one access; called at a negedge, returns at the next negedge
  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit rv, output bit rg,
                        output logic [15:0] rp, output logic [7:0] rvec);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    rv = rsp_valid; rd = rdata; rg = ring; rp = ring_peer; rvec = ring_vec;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; bit rv, rg; logic [15:0] rp; logic [7:0] rvec; bit exp_rg;
    exp_rg = (a[7:2] == 6'd3) && db_valid(d);
    access(1'b1, a, d, rd, rv, rg, rp, rvec);
    if (a[7:2] == 6'd0) mask_m = d;
    if (a[7:2] == 6'd1) stat_m = d;
    chk(rv == 1'b1, "R2 write response", 32'(rv), 1);
    chk(rg == exp_rg, "R8 R9 ring pulse", 32'(rg), 32'(exp_rg));
    if (exp_rg) begin
      chk(rp == d[31:16], "R8 ring peer", 32'(rp), 32'(d[31:16]));
      chk(rvec == d[7:0], "R8 ring vector", 32'(rvec), 32'(d[7:0]));
    end
    chk(irq == irq_exp(), "R5 irq after write", 32'(irq), 32'(irq_exp()));
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [31:0] rd, e; bit rv, rg; logic [15:0] rp; logic [7:0] rvec;
    e = rd_exp(a);
    access(1'b0, a, '0, rd, rv, rg, rp, rvec);
    if (a == 8'h04) stat_m = '0;
    chk(rv == 1'b1, "R2 read response", 32'(rv), 1);
    chk(rd == e, (a == 8'h04) ? "R4 status read" : "R3 R7 R10 read data", rd, e);
    chk(rg == 1'b0, "R8 no ring on read", 32'(rg), 0);
    chk(irq == irq_exp(), "R5 irq after read", 32'(irq), 32'(irq_exp()));
  endtask

  task automatic pulse_event(input logic [NOV-1:0] v);
    ev = v;
    @(negedge clk);
    ev = '0;
    if (!msi_mode && |v) stat_m = 32'd1;
    chk(irq == irq_exp(), "R6 irq after event", 32'(irq), 32'(irq_exp()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; bit rv, rg; logic [15:0] rp; logic [7:0] rvec;
    void'($urandom(32'd20240611));
    for (int p = 0; p < MAX_PEERS; p++) begin
      cnt_m[p] = (p == 3) ? 0 : int'($urandom % 33);
      cnt_tbl[p*CNT_W +: CNT_W] = CNT_W'(cnt_m[p]);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp idle in reset", 32'(rsp_valid), 0);
    chk(irq == 1'b0, "R1 irq low in reset", 32'(irq), 0);
    chk(ring == 1'b0, "R1 ring low in reset", 32'(ring), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 no response without request", 32'(rsp_valid), 0);
    do_read(8'h00);
    do_read(8'h04);

    // R3 full overwrite, low address bits ignored on write
    do_write(8'h03, 32'hdead_beef);
    do_read(8'h00);
    do_write(8'h06, 32'h0000_0100);
    do_read(8'h00);
    do_write(8'h04, 32'h8000_0101);
    // R5 masked status drives irq; R4 read clears
    do_read(8'h04);
    do_read(8'h04);

    // R6 event loads 1; msi mode ignores it and holds line low
    do_write(8'h00, 32'h0000_0001);
    pulse_event(4'b0100);
    chk(irq == 1'b1, "R6 R5 event raises irq", 32'(irq), 1);
    do_read(8'h04);
    msi_mode = 1'b1;
    pulse_event(4'b0001);
    do_read(8'h04);
    do_write(8'h04, 32'hffff_ffff);
    chk(irq == 1'b0, "R5 line low in message mode", 32'(irq), 0);
    msi_mode = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R5 line follows in line mode", 32'(irq), 1);
    do_read(8'h04);

    // R6 same-cycle priorities
    ev = 4'b1000;
    access(1'b0, 8'h04, '0, rd, rv, rg, rp, rvec);
    ev = '0;
    chk(rd == 32'h0, "R6 read returns pre-event value", rd, 0);
    stat_m = 32'd1;
    do_read(8'h04);
    ev = 4'b0010;
    access(1'b1, 8'h04, 32'h0000_0f00, rd, rv, rg, rp, rvec);
    ev = '0;
    stat_m = 32'h0000_0f00;
    do_read(8'h04);

    // R7 position read-only, R10 undefined offsets
    do_write(8'h08, 32'h1234_5678);
    do_read(8'h08);
    do_read(8'h0c);
    do_read(8'h0a);
    do_read(8'h40);
    do_write(8'h80, 32'hffff_ffff);
    do_write(8'hfc, 32'hffff_ffff);
    do_read(8'h00);
    do_read(8'h04);

    // R8 R9 doorbell corners
    begin
      int pv = 0;
      for (int p = 0; p < 10; p++) if (cnt_m[p] > 0 && p != 3) pv = p;
      do_write(8'h0c, {16'(pv), 8'hff, 8'(cnt_m[pv] - 1)});
      do_write(8'h0c, {16'(pv), 8'h00, 8'(cnt_m[pv])});
    end
    do_write(8'h0c, {16'd3, 16'd0});
    do_write(8'h0c, {16'd10, 16'd0});
    do_write(8'h0c, {16'd15, 16'd0});
    do_write(8'h0c, {16'hffff, 16'd0});
    do_write(8'h0d, {16'd0, 16'd0});

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom % 9);
      logic [31:0] d = $urandom;
      case (op)
        0: do_write({6'd0, 2'($urandom)}, d & 32'h0000_00ff);
        1: do_write({6'd1, 2'($urandom)}, d & 32'h0000_00ff);
        2: do_read(8'h04);
        3: do_read(8'h00);
        4: do_write(8'h0c, {16'($urandom % 20), d[15:8], 8'($urandom % 40)});
        5: pulse_event(NOV'($urandom));
        6: begin msi_mode = ~msi_mode; @(negedge clk); end
        7: do_write(8'($urandom) | 8'h10, d);
        default: do_read(8'($urandom));
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule